// File: doc/BRIEF.md
# Register-to-Register Execution Unit with Flag Register

This block executes the register-to-register operations of a small 8-bit processor. It holds sixteen general registers, V0 to VF, and the last of them also receives the carry, borrow or shifted-out bit of the arithmetic and shift operations. A caller gives two register indices, x and y, and a 4-bit function code. The unit reads Vx and Vy and writes the result back to Vx. For the functions that produce a flag, it also writes that flag into VF.

Each operation is started by a one-cycle `start` pulse. The register file is updated on the clock edge that samples `start`, and `done` is high for the cycle after that edge. A separate read port, with its own index, shows the contents of any register combinationally. After reset the registers hold a fixed pattern derived from parameters, so register values can be built from that pattern through the operations themselves. Function codes that are not defined report `illegal` together with `done` and leave every register unchanged.

Top module: `reg_alu_top`

## Requirements
- R1: After reset, register i reads (i*INIT_MUL + INIT_ADD) mod 2^DATA_W (defaults 37 and 5), and `done` and `illegal` are low.
- R2: `done` is high exactly in the cycle after each cycle in which `start` is high, and low otherwise. Register writes take effect on the edge that samples `start`. `view_data` shows register `view_idx` with no delay.
- R3: Function codes 0, 1, 2 and 3 write Vy, Vx OR Vy, Vx AND Vy and Vx XOR Vy, in that order, into Vx. VF is left unchanged unless x is 15.
- R4: Function 4 writes the low 8 bits of Vx + Vy into Vx. VF becomes 1 when the full sum exceeds 255 and 0 otherwise.
- R5: Function 5 writes Vx - Vy (mod 256) into Vx. VF becomes 1 only when Vx is strictly greater than Vy, so equal operands give VF = 0.
- R6: Function 7 writes Vy - Vx (mod 256) into Vx. VF becomes 1 only when Vy is strictly greater than Vx.
- R7: Function 6 writes Vx shifted right by one into Vx, and VF receives the old bit 0 of Vx.
- R8: Function 14 (hex E) writes Vx shifted left by one into Vx, and VF receives the old bit 7 of Vx.
- R9: Operand values are taken before the operation. When x is 15, the result overwrites the flag, so VF holds the result.
- R10: Function codes 8 to 13 and 15 change no register, and `illegal` is high together with `done` for that one cycle. `illegal` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts one operation in this cycle |
| x_idx | input | 4 | Index of the destination and first operand register |
| y_idx | input | 4 | Index of the second operand register |
| func | input | 4 | Function code |
| done | output | 1 | Operation completed (one cycle after `start`) |
| illegal | output | 1 | The completed operation had an undefined function code |
| view_idx | input | 4 | Index for the read port |
| view_data | output | 8 | Contents of register `view_idx` |

## Verification
The register file starts from its reset pattern. A few directed operations then run first: an add whose sum carries, subtractions with equal operands (to tell the strict test from greater-or-equal), shifts of values whose edge bits are set, operations that write to x = 15, and undefined codes. After these, several hundred operations run with random indices and random function codes. Because results feed later operations, the values and bit patterns keep changing. After every operation the whole register file is read back and compared with a model in the bench. This separates a wrong result from a wrong flag, and it shows a flag written after the result, or a stray write to some other register.

// File: rtl/reg_alu_pkg.sv
package reg_alu_pkg;
   localparam int FUNC_W = 4;

   typedef enum logic [FUNC_W-1:0] {
      FN_MOV  = 4'h0,
      FN_OR   = 4'h1,
      FN_AND  = 4'h2,
      FN_XOR  = 4'h3,
      FN_ADD  = 4'h4,
      FN_SUB  = 4'h5,
      FN_SHR  = 4'h6,
      FN_RSUB = 4'h7,
      FN_SHL  = 4'hE
   } alu_fn_e;
endpackage

// File: rtl/reg_alu_exec.sv
module reg_alu_exec
   import reg_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [FUNC_W-1:0] func,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic [DATA_W-1:0] res,
   output logic              res_we,
   output logic              flag,
   output logic              flag_we,
   output logic              bad_fn
);
   logic [DATA_W:0] sum_w;

   assign sum_w = {1'b0, opa} + {1'b0, opb};

   always_comb begin
      res     = opa;
      res_we  = 1'b1;
      flag    = 1'b0;
      flag_we = 1'b0;
      bad_fn  = 1'b0;
      case (func)
         FN_MOV:  res = opb;
         FN_OR:   res = opa | opb;
         FN_AND:  res = opa & opb;
         FN_XOR:  res = opa ^ opb;
         FN_ADD: begin
            res     = sum_w[DATA_W-1:0];
            flag    = sum_w[DATA_W];
            flag_we = 1'b1;
         end
         FN_SUB: begin
            res     = opa - opb;
            flag    = (opa > opb);
            flag_we = 1'b1;
         end
         FN_RSUB: begin
            res     = opb - opa;
            flag    = (opb > opa);
            flag_we = 1'b1;
         end
         FN_SHR: begin
            res     = opa >> 1;
            flag    = opa[0];
            flag_we = 1'b1;
         end
         FN_SHL: begin
            res     = opa << 1;
            flag    = opa[DATA_W-1];
            flag_we = 1'b1;
         end
         default: begin
            res_we = 1'b0;
            bad_fn = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/reg_alu_rf.sv
module reg_alu_rf #(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 16,
   parameter int INIT_MUL = 37,
   parameter int INIT_ADD = 5,
   localparam int IDX_W    = $clog2(NUM_REGS),
   localparam int FLAG_IDX = NUM_REGS - 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [IDX_W-1:0]           a_idx,
   input  logic [IDX_W-1:0]           b_idx,
   input  logic [IDX_W-1:0]           c_idx,
   output logic [DATA_W-1:0]          a_data,
   output logic [DATA_W-1:0]          b_data,
   output logic [DATA_W-1:0]          c_data,
   input  logic                       res_en,
   input  logic [IDX_W-1:0]           res_idx,
   input  logic [DATA_W-1:0]          res_data,
   input  logic                       flag_en,
   input  logic                       flag_bit,
   output logic [NUM_REGS*DATA_W-1:0] file_flat
);
   logic [DATA_W-1:0] regs [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam int unsigned           RAW  = i * INIT_MUL + INIT_ADD;
      localparam logic [DATA_W-1:0]     INIT = DATA_W'(RAW);
      logic hit_res;
      assign hit_res = res_en && (res_idx == IDX_W'(i));
      if (i == FLAG_IDX) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         regs[i] <= INIT;
            else if (hit_res)   regs[i] <= res_data;
            else if (flag_en)   regs[i] <= {{(DATA_W-1){1'b0}}, flag_bit};
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         regs[i] <= INIT;
            else if (hit_res)   regs[i] <= res_data;
         end
      end
      assign file_flat[i*DATA_W +: DATA_W] = regs[i];
   end

   assign a_data = regs[a_idx];
   assign b_data = regs[b_idx];
   assign c_data = regs[c_idx];
endmodule

// File: rtl/reg_alu_top.sv
module reg_alu_top
   import reg_alu_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 16,
   parameter int INIT_MUL = 37,
   parameter int INIT_ADD = 5,
   localparam int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [IDX_W-1:0]  x_idx,
   input  logic [IDX_W-1:0]  y_idx,
   input  logic [FUNC_W-1:0] func,
   output logic              done,
   output logic              illegal,
   input  logic [IDX_W-1:0]  view_idx,
   output logic [DATA_W-1:0] view_data
);
   if (DATA_W < 2) begin : g_bad_width
      $error("reg_alu_top: DATA_W must be at least 2");
   end
   if (NUM_REGS < 2 || (1 << IDX_W) != NUM_REGS) begin : g_bad_depth
      $error("reg_alu_top: NUM_REGS must be a power of two of at least 2");
   end

   logic [DATA_W-1:0]          opa, opb, res;
   logic                       res_we, flag, flag_we, bad_fn;
   logic [NUM_REGS*DATA_W-1:0] file_flat;
   logic                       done_q, illegal_q;

   reg_alu_exec #(.DATA_W(DATA_W)) u_exec (
      .func    (func),
      .opa     (opa),
      .opb     (opb),
      .res     (res),
      .res_we  (res_we),
      .flag    (flag),
      .flag_we (flag_we),
      .bad_fn  (bad_fn)
   );

   reg_alu_rf #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS),
      .INIT_MUL (INIT_MUL),
      .INIT_ADD (INIT_ADD)
   ) u_rf (
      .clk       (clk),
      .rst_n     (rst_n),
      .a_idx     (x_idx),
      .b_idx     (y_idx),
      .c_idx     (view_idx),
      .a_data    (opa),
      .b_data    (opb),
      .c_data    (view_data),
      .res_en    (start && res_we),
      .res_idx   (x_idx),
      .res_data  (res),
      .flag_en   (start && flag_we),
      .flag_bit  (flag),
      .file_flat (file_flat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q    <= 1'b0;
         illegal_q <= 1'b0;
      end else begin
         done_q    <= start;
         illegal_q <= start && bad_fn;
      end
   end

   assign done    = done_q;
   assign illegal = illegal_q;
endmodule

// File: rtl/reg_alu_chk.sv
module reg_alu_chk #(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 16,
   localparam int IDX_W    = $clog2(NUM_REGS)
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       start,
   input logic [IDX_W-1:0]           x_idx,
   input logic [3:0]                 func,
   input logic                       done,
   input logic                       illegal,
   input logic [DATA_W-1:0]          opa,
   input logic [DATA_W-1:0]          opb,
   input logic [NUM_REGS*DATA_W-1:0] file_flat
);
   logic [DATA_W-1:0] vf;
   logic [DATA_W:0]   wide_sum;

   assign vf       = file_flat[(NUM_REGS-1)*DATA_W +: DATA_W];
   assign wide_sum = {1'b0, opa} + {1'b0, opb};

   a_r2_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done);

   a_r2_done_only_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done);

   a_r10_illegal_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> done);

   a_r10_regs_kept: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> file_flat == $past(file_flat));

   a_r4_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(start) && $past(func) == 4'h4 && $past(x_idx) != IDX_W'(NUM_REGS-1))
      |-> vf == {{(DATA_W-1){1'b0}}, $past(wide_sum[DATA_W])});

   a_r3_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(start) && $past(func) < 4'h4 && $past(x_idx) != IDX_W'(NUM_REGS-1))
      |-> vf == $past(vf));
endmodule

bind reg_alu_top reg_alu_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .x_idx     (x_idx),
   .func      (func),
   .done      (done),
   .illegal   (illegal),
   .opa       (opa),
   .opb       (opb),
   .file_flat (file_flat)
);

// File: tb/tb_reg_alu_top.sv
`timescale 1ns/100ps
module tb_reg_alu_top;
   localparam int W = 8;
   localparam int N = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [3:0] x_idx = '0, y_idx = '0, func = '0, view_idx = '0;
   logic       done, illegal;
   logic [7:0] view_data;

   int checks = 0;
   int errors = 0;
   logic [7:0] model [N];

   always #2.5 clk = ~clk;

   reg_alu_top dut (
      .clk(clk), .rst_n(rst_n), .start(start), .x_idx(x_idx), .y_idx(y_idx),
      .func(func), .done(done), .illegal(illegal),
      .view_idx(view_idx), .view_data(view_data)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [3:0] f, input logic [3:0] x);
      if (f > 4'h7 && f != 4'hE) return "R10";
      if (x == 4'hF && f >= 4'h4) return "R9";
      case (f)
         4'h4:    return "R4";
         4'h5:    return "R5";
         4'h6:    return "R7";
         4'h7:    return "R6";
         4'hE:    return "R8";
         default: return "R3";
      endcase
   endfunction

   // Updates the bench model per the requirements; returns 1 for undefined codes.
   function automatic bit apply_model(input logic [3:0] x, input logic [3:0] y, input logic [3:0] f);
      logic [7:0] a = model[x];
      logic [7:0] b = model[y];
      logic [8:0] s = {1'b0, a} + {1'b0, b};
      case (f)
         4'h0: model[x] = b;
         4'h1: model[x] = a | b;
         4'h2: model[x] = a & b;
         4'h3: model[x] = a ^ b;
         4'h4: begin model[15] = {7'd0, s[8]};   model[x] = s[7:0]; end
         4'h5: begin model[15] = {7'd0, a > b};  model[x] = a - b;  end
         4'h7: begin model[15] = {7'd0, b > a};  model[x] = b - a;  end
         4'h6: begin model[15] = {7'd0, a[0]};   model[x] = a >> 1; end
         4'hE: begin model[15] = {7'd0, a[7]};   model[x] = a << 1; end
         default: return 1'b1;
      endcase
      return 1'b0;
   endfunction

   task automatic compare_file(input string req);
      for (int i = 0; i < N; i++) begin
         view_idx = 4'(i);
         #0.1;
         check(view_data === model[i], req, view_data, model[i]);
      end
   endtask

   task automatic run_op(input logic [3:0] x, input logic [3:0] y, input logic [3:0] f);
      bit bad;
      string req;
      req = tag_of(f, x);
      bad = apply_model(x, y, f);
      @(negedge clk);
      x_idx = x; y_idx = y; func = f; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(done === 1'b1, "R2", done, 1);
      check(illegal === bad, "R10", illegal, bad);
      compare_file(req);
      @(negedge clk);
      check(done === 1'b0, "R2", done, 0);
      check(illegal === 1'b0, "R10", illegal, 0);
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'd20511);
      for (int i = 0; i < N; i++) model[i] = 8'(i * 37 + 5);
      #12 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset contents and idle outputs
      check(done === 1'b0, "R1", done, 0);
      check(illegal === 1'b0, "R1", illegal, 0);
      compare_file("R1");

      // Directed corner cases
      run_op(4'h6, 4'h5, 4'h4);   // R4: 227+190 carries
      run_op(4'h1, 4'h1, 4'h5);   // R5: equal operands, strict test gives 0
      run_op(4'h2, 4'h3, 4'h7);   // R6: Vy > Vx
      run_op(4'h3, 4'h2, 4'h7);   // R6: Vy < Vx
      run_op(4'h0, 4'h0, 4'h6);   // R7: bit 0 set
      run_op(4'h4, 4'h4, 4'hE);   // R8: bit 7 set
      run_op(4'hF, 4'h9, 4'h4);   // R9: result replaces flag
      run_op(4'hF, 4'hA, 4'h5);   // R9
      run_op(4'hA, 4'hB, 4'h3);   // R3: XOR
      run_op(4'hC, 4'hD, 4'h0);   // R3: move
      run_op(4'h8, 4'h9, 4'h8);   // R10: undefined
      run_op(4'hF, 4'h1, 4'hF);   // R10: undefined, x=15
      run_op(4'h7, 4'h7, 4'hD);   // R10

      // Random operations
      for (int k = 0; k < 400; k++) begin
         run_op(4'($urandom), 4'($urandom), 4'($urandom));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule